// File: doc/BRIEF.md
# A/D Scan Controller with Byte FIFO

This block runs analog-to-digital conversions over a span of channels and stores every result in a byte-wide FIFO. A trigger starts a pass. The trigger is either a software command or, when the A/D interrupt enable is set, a pulse from an on-board timer or an external source. On a pass the controller drives a simple start/busy/data handshake toward the converter, one channel after another. Each 16-bit result is written into the FIFO as two bytes.

The host reads bytes back one at a time. It sees the fill level as a byte count, a sticky overflow flag and a busy indication. An interrupt request rises when the fill level reaches a programmed threshold. A write-one command port carries three commands: start, interrupt clear and FIFO reset.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The FIFO holds 4096 bytes (2048 samples). `depth` is a 13-bit count of the bytes held. After reset, `depth`, `overflow`, `irq` and `busy` are 0.
- R2: Each finished conversion writes two bytes, low byte first and then high byte. `rdData` shows the oldest byte while `depth` is nonzero. A pulse on `rdEn` removes that byte. A `rdEn` pulse on an empty FIFO has no effect.
- R3: A byte write that meets a full FIFO (4096 bytes held) is dropped and sets `overflow`. `overflow` stays set until a FIFO reset.
- R4: The FIFO-reset command (`cmdBits` bit 2) sets `depth` to 0 and clears `overflow`. A byte write or read in the same cycle is discarded.
- R5: The start command (`cmdBits` bit 0) begins a pass only while `intEn` is 0. `timerTrig` and `extTrig` begin a pass only while `intEn` is 1.
- R6: With `scanEn` set, one trigger converts channels `chanLow` up to `chanHigh` inclusive, in ascending order. With `scanEn` clear, or with `chanHigh` not above `chanLow`, only `chanLow` is converted. A trigger that arrives during a pass is ignored.
- R7: With `scanEn` and `intEn` both 0, `busy` equals `convBusy`. Otherwise `busy` is high from the cycle after a trigger is accepted until the last high byte of the pass is written.
- R8: With `intEn` at 1, `irq` sets when an accepted byte write leaves `depth` equal to a nonzero `threshold`. The interrupt-clear command (`cmdBits` bit 1) clears `irq`. A set in the same cycle as a clear wins. `irq` never sets while `intEn` is 0.
- R9: A command write with more than one bit of `cmdBits` set is ignored as a whole.
- R10: `convStart` is a one-cycle pulse that presents the channel on `convChan`. A result is taken from `convData` on the first cycle that `convBusy` is low after it went high.
- R11: A byte write and a read in the same cycle leave `depth` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Convert the whole channel span on each trigger |
| intEn | input | 1 | A/D interrupt enable; selects hardware triggers |
| chanLow | input | 5 | First channel of a pass |
| chanHigh | input | 5 | Last channel of a scan |
| threshold | input | 13 | Byte count that raises the interrupt |
| cmdWrite | input | 1 | Command write strobe |
| cmdBits | input | 3 | Command bits: 0 start, 1 interrupt clear, 2 FIFO reset |
| timerTrig | input | 1 | Timer trigger pulse |
| extTrig | input | 1 | External trigger pulse |
| convStart | output | 1 | Conversion start pulse to the converter |
| convChan | output | 5 | Channel for the conversion |
| convBusy | input | 1 | Converter busy status |
| convData | input | 16 | Converter result |
| rdEn | input | 1 | Pop one byte |
| rdData | output | 8 | Oldest byte in the FIFO |
| depth | output | 13 | Bytes held |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Conversion activity |

## Verification
Byte writes from the sequencer fall on fixed cycles after `convBusy` drops, so the host-side actions can be made to land on them exactly. The bench watches for the drop and aims an interrupt clear, a read or a FIFO reset at the cycle the low byte is written. It then expects, in turn: `irq` still set, `depth` unchanged, and `depth` at zero with only the high byte arriving afterwards. A behavioural model built from byte queues predicts `depth`, `rdData`, `overflow` and `irq` on every cycle, which also covers these collisions during normal traffic.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int CMD_W    = 3;
  localparam int CMD_START    = 0;
  localparam int CMD_IRQ_CLR  = 1;
  localparam int CMD_FIFO_CLR = 2;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_WAIT_HI,
    SEQ_WAIT_LO,
    SEQ_PUSH_LO,
    SEQ_PUSH_HI
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic pushLo;
    logic pushHi;
    logic fifoClr;
    logic irqClr;
  } dpStrobe_t;
endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanEn,
  input  logic              intEn,
  input  logic [CHAN_W-1:0] chanLow,
  input  logic [CHAN_W-1:0] chanHigh,
  input  logic              cmdWrite,
  input  logic [CMD_W-1:0]  cmdBits,
  input  logic              timerTrig,
  input  logic              extTrig,
  input  logic              convBusy,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output logic              seqActive,
  output dpStrobe_t         strb
);
  seqState_t         state;
  logic [CHAN_W-1:0] curChan;
  logic [CHAN_W-1:0] endChan;
  logic              cmdValid;
  logic              swGo;
  logic              hwGo;
  logic              trigGo;

  assign cmdValid = cmdWrite && $onehot(cmdBits);
  assign swGo     = cmdValid && cmdBits[CMD_START] && !intEn;
  assign hwGo     = intEn && (timerTrig || extTrig);
  assign trigGo   = (swGo || hwGo) && (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      curChan <= '0;
      endChan <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (trigGo) begin
          curChan <= chanLow;
          endChan <= (scanEn && (chanHigh > chanLow)) ? chanHigh : chanLow;
          state   <= SEQ_START;
        end
        SEQ_START:   state <= SEQ_WAIT_HI;
        SEQ_WAIT_HI: if (convBusy) state <= SEQ_WAIT_LO;
        SEQ_WAIT_LO: if (!convBusy) state <= SEQ_PUSH_LO;
        SEQ_PUSH_LO: state <= SEQ_PUSH_HI;
        SEQ_PUSH_HI: begin
          if (curChan != endChan) begin
            curChan <= curChan + CHAN_W'(1);
            state   <= SEQ_START;
          end else begin
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign convStart    = (state == SEQ_START);
  assign convChan     = curChan;
  assign seqActive    = (state != SEQ_IDLE);
  assign strb.capture = (state == SEQ_WAIT_LO) && !convBusy;
  assign strb.pushLo  = (state == SEQ_PUSH_LO);
  assign strb.pushHi  = (state == SEQ_PUSH_HI);
  assign strb.fifoClr = cmdValid && cmdBits[CMD_FIFO_CLR];
  assign strb.irqClr  = cmdValid && cmdBits[CMD_IRQ_CLR];

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R10
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && $past(state) == SEQ_PUSH_HI) |-> (convChan == $past(convChan) + CHAN_W'(1))); // R6
  AST_SW_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && intEn && !timerTrig && !extTrig) |=> (state == SEQ_IDLE)); // R5
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && !intEn && cmdWrite && $countones(cmdBits) > 1) |=> (state == SEQ_IDLE)); // R9
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo
  import adc_scan_pkg::*;
#(
  parameter int FIFO_BYTES = 4096,
  localparam int PTR_W   = $clog2(FIFO_BYTES),
  localparam int DEPTH_W = PTR_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] convData,
  input  logic                rdEn,
  input  logic                intEn,
  input  logic [DEPTH_W-1:0]  threshold,
  output logic [BYTE_W-1:0]   rdData,
  output logic [DEPTH_W-1:0]  depth,
  output logic                overflow,
  output logic                irq
);
  logic [BYTE_W-1:0]   mem [FIFO_BYTES];
  logic [SAMPLE_W-1:0] sampleReg;
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [DEPTH_W-1:0]  count;
  logic [DEPTH_W-1:0]  countNext;
  logic [BYTE_W-1:0]   wrByte;
  logic                wrReq;
  logic                full;
  logic                wrOk;
  logic                rdOk;

  assign wrReq  = strb.pushLo || strb.pushHi;
  assign wrByte = strb.pushHi ? sampleReg[SAMPLE_W-1:BYTE_W] : sampleReg[BYTE_W-1:0];
  assign full   = (count == DEPTH_W'(FIFO_BYTES));
  assign wrOk   = wrReq && !full && !strb.fifoClr;
  assign rdOk   = rdEn && (count != '0) && !strb.fifoClr;

  always_comb countNext = count + DEPTH_W'(wrOk) - DEPTH_W'(rdOk);

  always_ff @(posedge clk) begin
    if (strb.capture) sampleReg <= convData;
    if (wrOk) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (strb.fifoClr) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + PTR_W'(1);
      if (rdOk) rdPtr <= rdPtr + PTR_W'(1);
      count <= countNext;
      if (wrReq && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else if (wrOk && intEn && threshold != '0 && countNext == threshold) irq <= 1'b1;
    else if (strb.irqClr) irq <= 1'b0;
  end

  assign rdData = mem[rdPtr];
  assign depth  = count;

  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_W'(FIFO_BYTES)); // R1
  AST_LO_BEFORE_HI: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushHi |-> $past(strb.pushLo)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && full && !rdEn && !strb.fifoClr) |=> (count == $past(count) && overflow)); // R3
  AST_FIFO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.fifoClr |=> (count == '0 && !overflow)); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(intEn)); // R8
  AST_RD_WR_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && rdEn && !full && count != '0 && !strb.fifoClr) |=> (count == $past(count))); // R11
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CHAN_W     = 5,
  parameter int FIFO_BYTES = 4096,
  localparam int DEPTH_W   = $clog2(FIFO_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanEn,
  input  logic                intEn,
  input  logic [CHAN_W-1:0]   chanLow,
  input  logic [CHAN_W-1:0]   chanHigh,
  input  logic [DEPTH_W-1:0]  threshold,
  input  logic                cmdWrite,
  input  logic [CMD_W-1:0]    cmdBits,
  input  logic                timerTrig,
  input  logic                extTrig,
  output logic                convStart,
  output logic [CHAN_W-1:0]   convChan,
  input  logic                convBusy,
  input  logic [SAMPLE_W-1:0] convData,
  input  logic                rdEn,
  output logic [BYTE_W-1:0]   rdData,
  output logic [DEPTH_W-1:0]  depth,
  output logic                overflow,
  output logic                irq,
  output logic                busy
);
  dpStrobe_t strb;
  logic      seqActive;

  adc_scan_seq #(.CHAN_W(CHAN_W)) u_seq (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .intEn(intEn),
    .chanLow(chanLow), .chanHigh(chanHigh),
    .cmdWrite(cmdWrite), .cmdBits(cmdBits),
    .timerTrig(timerTrig), .extTrig(extTrig), .convBusy(convBusy),
    .convStart(convStart), .convChan(convChan),
    .seqActive(seqActive), .strb(strb)
  );

  adc_scan_fifo #(.FIFO_BYTES(FIFO_BYTES)) u_fifo (
    .clk(clk), .rstN(rstN), .strb(strb), .convData(convData),
    .rdEn(rdEn), .intEn(intEn), .threshold(threshold),
    .rdData(rdData), .depth(depth), .overflow(overflow), .irq(irq)
  );

  assign busy = (!scanEn && !intEn) ? convBusy : seqActive;
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanEn = 1'b0, intEn = 1'b0;
  logic [4:0]  chanLow = '0, chanHigh = '0;
  logic [12:0] threshold = '0;
  logic        cmdWrite = 1'b0;
  logic [2:0]  cmdBits = '0;
  logic        timerTrig = 1'b0, extTrig = 1'b0, rdEn = 1'b0;
  logic        convBusy = 1'b0;
  logic [15:0] convData = '0;
  logic        convStart, overflow, irq, busy;
  logic [4:0]  convChan;
  logic [7:0]  rdData;
  logic [12:0] depth;

  adc_scan_ctrl #(.FIFO_BYTES(CAP)) u_dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .intEn(intEn),
    .chanLow(chanLow), .chanHigh(chanHigh), .threshold(threshold),
    .cmdWrite(cmdWrite), .cmdBits(cmdBits), .timerTrig(timerTrig), .extTrig(extTrig),
    .convStart(convStart), .convChan(convChan), .convBusy(convBusy), .convData(convData),
    .rdEn(rdEn), .rdData(rdData), .depth(depth), .overflow(overflow), .irq(irq), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nRun = 0, nFail = 0, cyc = 0;

  task automatic check(string req, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [4:0] ch, int n);
    return {3'b101, ch, n[7:0]};
  endfunction

  // converter model and start-pulse monitor (R10)
  int         rem = 0, convCount = 0;
  logic [4:0] lastChan = '0;
  logic       prevStart = 1'b0;
  logic [4:0] seenQ[$];
  int         pendAt[$];
  logic [7:0] pendVal[$];

  always @(negedge clk) begin
    if (rstN) begin
      if (convStart && prevStart) check("R10", "start pulse longer than one cycle", 1, 0);
      prevStart = convStart;
      if (convStart) begin
        seenQ.push_back(convChan);
        lastChan = convChan;
        convBusy = 1'b1;
        rem = 3;
      end else if (rem > 0) begin
        rem--;
        if (rem == 0) begin
          convBusy = 1'b0;
          convData = mk(lastChan, convCount);
          convCount++;
          pendAt.push_back(cyc + 2); pendVal.push_back(convData[7:0]);
          pendAt.push_back(cyc + 3); pendVal.push_back(convData[15:8]);
        end
      end
    end
  end

  // behavioural reference of the byte store
  logic [7:0] mq[$];
  bit mOvf = 0, mIrq = 0;

  always @(posedge clk) begin : mdl
    bit hasPush, okCmd, clr, irqc, doRd, doWr, setEv;
    logic [7:0] pv;
    cyc++;
    if (!rstN) begin
      mq.delete(); mOvf = 0; mIrq = 0;
    end else begin
      hasPush = 0; pv = '0;
      if (pendAt.size() > 0 && pendAt[0] == cyc) begin
        hasPush = 1; pv = pendVal[0];
        void'(pendAt.pop_front()); void'(pendVal.pop_front());
      end
      okCmd = cmdWrite && ($countones(cmdBits) == 1);
      clr   = okCmd && cmdBits[2];
      irqc  = okCmd && cmdBits[1];
      setEv = 0;
      if (clr) begin
        mq.delete(); mOvf = 0;
      end else begin
        doRd = rdEn && mq.size() > 0;
        doWr = hasPush && mq.size() < CAP;
        if (hasPush && !doWr) mOvf = 1;
        if (doRd) void'(mq.pop_front());
        if (doWr) begin
          mq.push_back(pv);
          if (intEn && threshold != 0 && mq.size() == int'(threshold)) setEv = 1;
        end
      end
      if (setEv) mIrq = 1;
      else if (irqc) mIrq = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      check("R1", "depth vs model", int'(depth), mq.size());
      check("R3", "overflow vs model", int'(overflow), int'(mOvf));
      check("R8", "irq vs model", int'(irq), int'(mIrq));
      if (mq.size() > 0) check("R2", "head byte vs model", int'(rdData), int'(mq[0]));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic cmd(logic [2:0] b);
    cmdWrite = 1'b1; cmdBits = b;
    tick();
    cmdWrite = 1'b0; cmdBits = '0;
  endtask

  task automatic waitIdle();
    tick();
    for (int i = 0; i < 4000 && busy; i++) tick();
  endtask

  task automatic waitBusyFall();
    for (int i = 0; i < 100 && !convBusy; i++) tick();
    for (int i = 0; i < 100 && convBusy; i++) tick();
  endtask

  task automatic pulseTimer();
    timerTrig = 1'b1; tick(); timerTrig = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("R1", "watchdog expired", 1, 0);
    summary();
  end

  initial begin
    int base, d;
    tick(3);
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1", "depth after reset", int'(depth), 0);
    check("R1", "overflow after reset", int'(overflow), 0);
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "busy after reset", int'(busy), 0);

    // single conversion, software start, busy mirror (R7), bytes (R2)
    chanLow = 5'd3; threshold = 13'd2;
    base = seenQ.size();
    cmd(3'b001);
    for (int i = 0; i < 8; i++) begin
      check("R7", "busy mirrors convBusy", int'(busy), int'(convBusy));
      tick();
    end
    check("R5", "one software-started conversion", seenQ.size() - base, 1);
    if (seenQ.size() > base) check("R10", "channel presented", int'(seenQ[base]), 3);
    check("R2", "two bytes per result", int'(depth), 2);
    check("R8", "no irq with intEn low", int'(irq), 0);
    check("R2", "low byte first", int'(rdData), int'(mk(5'd3, 0) & 16'h00ff));
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    check("R2", "high byte second", int'(rdData), int'(mk(5'd3, 0) >> 8));
    rdEn = 1'b1; tick(2); rdEn = 1'b0;
    check("R2", "read on empty ignored", int'(depth), 0);

    // scan span (R6)
    scanEn = 1'b1; chanLow = 5'd4; chanHigh = 5'd7;
    base = seenQ.size();
    cmd(3'b001);
    check("R7", "busy high during scan", int'(busy), 1);
    cmd(3'b001);
    waitIdle();
    check("R6", "scan conversion count", seenQ.size() - base, 4);
    for (int i = 0; i < 4 && base + i < seenQ.size(); i++)
      check("R6", "scan channel order", int'(seenQ[base + i]), 4 + i);
    check("R6", "bytes from scan", int'(depth), 8);
    check("R7", "busy low after scan", int'(busy), 0);
    chanLow = 5'd9; chanHigh = 5'd6;
    base = seenQ.size();
    cmd(3'b001); waitIdle();
    check("R6", "reversed span gives one channel", seenQ.size() - base, 1);

    // trigger source selection (R5)
    scanEn = 1'b0; intEn = 1'b1; chanLow = 5'd2;
    base = seenQ.size(); d = int'(depth);
    cmd(3'b001); tick(10);
    check("R5", "software start blocked with intEn", seenQ.size() - base, 0);
    check("R5", "depth unchanged after blocked start", int'(depth), d);
    pulseTimer(); waitIdle();
    extTrig = 1'b1; tick(); extTrig = 1'b0; waitIdle();
    check("R5", "timer and external triggers", seenQ.size() - base, 2);
    intEn = 1'b0;
    base = seenQ.size();
    pulseTimer(); tick(10);
    check("R5", "timer ignored with intEn low", seenQ.size() - base, 0);

    // illegal multi-bit command (R9)
    d = int'(depth); base = seenQ.size();
    cmd(3'b101); tick(10);
    check("R9", "multi-bit command ignored (depth)", int'(depth), d);
    check("R9", "multi-bit command ignored (start)", seenQ.size() - base, 0);

    // FIFO reset (R4)
    cmd(3'b100);
    check("R4", "depth cleared", int'(depth), 0);

    // interrupt threshold (R8)
    intEn = 1'b1; threshold = 13'd3;
    pulseTimer(); waitIdle();
    check("R8", "irq low below threshold", int'(irq), 0);
    pulseTimer(); waitIdle();
    check("R8", "irq set at threshold", int'(irq), 1);
    cmd(3'b010);
    check("R8", "irq cleared", int'(irq), 0);
    threshold = 13'd5;
    pulseTimer(); waitBusyFall();
    cmd(3'b010);
    check("R8", "set wins over same-cycle clear", int'(irq), 1);
    waitIdle(); cmd(3'b010);

    // read and write together (R11)
    d = int'(depth);
    pulseTimer(); waitBusyFall();
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    check("R11", "read with write keeps depth", int'(depth), d);
    waitIdle();

    // FIFO reset against a write (R4)
    pulseTimer(); waitBusyFall();
    cmd(3'b100);
    check("R4", "write discarded by reset", int'(depth), 0);
    tick();
    check("R4", "next byte lands after reset", int'(depth), 1);
    check("R2", "remaining byte is high half", int'(rdData), int'(convData >> 8));
    waitIdle();

    // fill to capacity, overflow (R3)
    cmd(3'b100);
    intEn = 1'b0; threshold = '0; scanEn = 1'b1; chanLow = 5'd0; chanHigh = 5'd31;
    for (int s = 0; s < 64; s++) begin
      cmd(3'b001); waitIdle();
    end
    check("R1", "full at 4096 bytes", int'(depth), CAP);
    check("R3", "no overflow at exact fill", int'(overflow), 0);
    scanEn = 1'b0;
    cmd(3'b001); tick(10);
    check("R3", "depth held when full", int'(depth), CAP);
    check("R3", "overflow set", int'(overflow), 1);
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    check("R3", "overflow sticky", int'(overflow), 1);
    cmd(3'b100);
    check("R4", "reset clears overflow", int'(overflow), 0);
    check("R4", "reset empties", int'(depth), 0);
    tick(2);
    summary();
  end
endmodule